// File: doc/BRIEF.md
# Processor Clock Prescaler with Low-Power Gating

This block runs on a single oscillator clock and produces two clock-enable pulse streams for the rest of the subsystem. The processor enable fires at the oscillator rate divided by a divisor chosen through a 3-bit select field. It is gated off while either the idle request or the power-down request is held. The peripheral enable fires on every oscillator cycle, and only power-down stops it. Downstream logic qualifies its registers with these enables, so the block creates no derived clocks.

A small register interface loads the divisor select together with a debug-comparator enable flag. A second write port loads the idle and power-down requests. A divisor change takes effect at once: the write restarts the internal division counter, so the first pulse at the new rate lands in the cycle that follows the write.

Top module: `clk_prescale_gate`

## Requirements
- R1: The select field picks the processor-enable divisor: code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 16, 5 gives 32, 6 gives 1024 and 7 gives 2048. While the enable is ungated, `cpu_ce` pulses exactly once in each divisor-length period.
- R2: After reset, the select field is 0, `cpu_ce` and `per_ce` are high on every cycle, and `dbg_cmp_en` is 1.
- R3: A write to the select field (`cfg_we` high at a clock edge) restarts the division counter at zero. If the enable is ungated, `cpu_ce` is high in the cycle right after that edge, without waiting for the old period to end.
- R4: While the stored idle bit or the stored power-down bit is 1, `cpu_ce` stays low.
- R5: `per_ce` is high on every cycle while the stored power-down bit is 0, whatever the idle bit is, and low while it is 1.
- R6: `dbg_cmp_en` follows the value of `cfg_dbg` written with `cfg_we`, and it is 1 after reset.
- R7: While the processor enable is gated, the division counter holds its value. When gating is released, counting resumes from the held value and is not restarted.
- R8: `pwr_we` high at a clock edge loads `pwr_idle` and `pwr_pd` into the stored idle and power-down bits, and both bits are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for divisor select and debug enable |
| cfg_sel | input | 3 | Divisor select code (see R1) |
| cfg_dbg | input | 1 | Debug-comparator enable value to write |
| pwr_we | input | 1 | Write strobe for the low-power requests |
| pwr_idle | input | 1 | Idle request value to write |
| pwr_pd | input | 1 | Power-down request value to write |
| cpu_ce | output | 1 | Processor clock-enable pulse |
| per_ce | output | 1 | Peripheral clock-enable pulse |
| dbg_cmp_en | output | 1 | Debug-comparator enable flag |

## Verification
Assertions check the gating rules on every cycle: `cpu_ce` is never high while idle or power-down is stored, and `per_ce` tracks the power-down bit exactly. They also check that a select write zeroes the counter and produces an immediate pulse, that a gated counter holds still, and that divide-by-one fires on every ungated cycle. The exact pulse counts for each divisor, and the point where the first pulse lands after a gated counter resumes mid-period, show up only in the bench's windowed pulse counts. The reset values appear in the bench's reset-state check.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  localparam int SEL_W   = 3;
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int CNT_W   = 11;

  // log2 of the divisor for each select code: 0..5 map straight,
  // 6 and 7 jump to 10 and 11.
  function automatic int sel_shift(input int code);
    if (code < 6) return code;
    return code + 4;
  endfunction
endpackage

// File: rtl/cpg_rst_sync.sv
module cpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/cpg_ctrl_regs.sv
module cpg_ctrl_regs #(
  parameter int SEL_W = cpg_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_dbg,
  input  logic             pwr_we,
  input  logic             pwr_idle,
  input  logic             pwr_pd,
  output logic [SEL_W-1:0] sel_q,
  output logic             dbg_q,
  output logic             idle_q,
  output logic             pd_q
);
  logic [SEL_W-1:0] sel_d;
  logic             dbg_d, idle_d, pd_d;

  always_comb begin
    sel_d  = sel_q;
    dbg_d  = dbg_q;
    idle_d = idle_q;
    pd_d   = pd_q;
    if (cfg_we) begin
      sel_d = cfg_sel;
      dbg_d = cfg_dbg;
    end
    if (pwr_we) begin
      idle_d = pwr_idle;
      pd_d   = pwr_pd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      dbg_q  <= 1'b1;
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      dbg_q  <= dbg_d;
      idle_q <= idle_d;
      pd_q   <= pd_d;
    end
  end

  AST_PWR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_we |=> (idle_q == $past(pwr_idle)) && (pd_q == $past(pwr_pd))); // R8
  AST_DBG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (dbg_q == $past(cfg_dbg))); // R6
endmodule

// File: rtl/cpg_divider.sv
module cpg_divider #(
  parameter int SEL_W = cpg_pkg::SEL_W,
  parameter int CNT_W = cpg_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NSEL-1:0]  hit;

  // One terminal-count decode per select code.
  for (genvar s = 0; s < NSEL; s++) begin : g_hit
    localparam int SH = cpg_pkg::sel_shift(s);
    localparam logic [CNT_W-1:0] MASK = {CNT_W{1'b1}} >> (CNT_W - SH);
    assign hit[s] = ((cnt_q & MASK) == '0);
  end

  assign tick = run & hit[sel];

  always_comb begin
    cnt_d = cnt_q;
    if (restart)  cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R3
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt_q)); // R7
  AST_DIV1_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel == '0) |-> tick); // R1
endmodule

// File: rtl/clk_prescale_gate.sv
module clk_prescale_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_sel,
  input  logic       cfg_dbg,
  input  logic       pwr_we,
  input  logic       pwr_idle,
  input  logic       pwr_pd,
  output logic       cpu_ce,
  output logic       per_ce,
  output logic       dbg_cmp_en
);
  localparam int SEL_W = cpg_pkg::SEL_W;
  localparam int CNT_W = cpg_pkg::CNT_W;

  logic             rst_sync_n;
  logic [SEL_W-1:0] sel_q;
  logic             idle_q, pd_q, cpu_run;

  cpg_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  cpg_ctrl_regs #(.SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cfg_we  (cfg_we),
    .cfg_sel (cfg_sel),
    .cfg_dbg (cfg_dbg),
    .pwr_we  (pwr_we),
    .pwr_idle(pwr_idle),
    .pwr_pd  (pwr_pd),
    .sel_q   (sel_q),
    .dbg_q   (dbg_cmp_en),
    .idle_q  (idle_q),
    .pd_q    (pd_q)
  );

  assign cpu_run = ~idle_q & ~pd_q;

  cpg_divider #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (cpu_run),
    .restart(cfg_we),
    .sel    (sel_q),
    .tick   (cpu_ce)
  );

  assign per_ce = ~pd_q;

  AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (idle_q || pd_q) |-> !cpu_ce); // R4
  AST_PER_STOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pd_q |-> !per_ce); // R5
  AST_PER_RUN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pd_q |-> per_ce); // R5
  AST_NEW_RATE_NOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(cfg_we) && !idle_q && !pd_q) |-> cpu_ce); // R3
endmodule

// File: tb/tb_clk_prescale_gate.sv
module tb_clk_prescale_gate;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, cfg_dbg, pwr_we, pwr_idle, pwr_pd;
  logic [2:0] cfg_sel;
  logic       cpu_ce, per_ce, dbg_cmp_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  clk_prescale_gate dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_dbg(cfg_dbg),
    .pwr_we(pwr_we), .pwr_idle(pwr_idle), .pwr_pd(pwr_pd),
    .cpu_ce(cpu_ce), .per_ce(per_ce), .dbg_cmp_en(dbg_cmp_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write.
  task automatic wr_sel(input logic [2:0] s, input logic d);
    cfg_sel = s; cfg_dbg = d; cfg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_pwr(input logic i, input logic p);
    pwr_idle = i; pwr_pd = p; pwr_we = 1'b1;
    @(posedge clk); @(negedge clk);
    pwr_we = 1'b0;
  endtask

  task automatic count_win(input int w, output int nc, output int np, output int first);
    nc = 0; np = 0; first = -1;
    for (int i = 0; i < w; i++) begin
      if (cpu_ce) begin
        if (first < 0) first = i;
        nc++;
      end
      if (per_ce) np++;
      @(negedge clk);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int nc, np, first, dv;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_dbg = 1'b1;
    pwr_we = 1'b0; pwr_idle = 1'b0; pwr_pd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    chk("R2 dbg after reset", int'(dbg_cmp_en), 1);
    count_win(16, nc, np, first);
    chk("R2 cpu_ce every cycle after reset", nc, 16);
    chk("R2 per_ce every cycle after reset", np, 16);

    // R1 sweep of every select code over a 4096-cycle window
    for (int s = 0; s < 8; s++) begin
      dv = (s < 6) ? (1 << s) : (1 << (s + 4));
      wr_sel(3'(s), 1'b1);
      count_win(4096, nc, np, first);
      chk($sformatf("R1 pulses for code %0d", s), nc, (4096 + dv - 1) / dv);
      chk($sformatf("R3 first pulse offset code %0d", s), first, 0);
    end

    // R3 new select takes effect in the middle of a long period
    wr_sel(3'd7, 1'b1);
    count_win(100, nc, np, first);
    chk("R3 one pulse early in /2048", nc, 1);
    wr_sel(3'd1, 1'b1);
    count_win(8, nc, np, first);
    chk("R3 immediate /2 first offset", first, 0);
    chk("R3 immediate /2 count", nc, 4);

    // R4 R5 R8 every gating combination with /4
    for (int g = 0; g < 4; g++) begin
      wr_pwr(g[0], g[1]);
      wr_sel(3'd2, 1'b1);
      count_win(64, nc, np, first);
      chk($sformatf("R4 cpu pulses idle=%0d pd=%0d", g[0], g[1]), nc, (g == 0) ? 16 : 0);
      chk($sformatf("R5 per pulses idle=%0d pd=%0d", g[0], g[1]), np, g[1] ? 0 : 64);
    end

    // R7 counter hold across gating
    wr_pwr(1'b1, 1'b0);
    wr_sel(3'd3, 1'b1);
    count_win(20, nc, np, first);
    chk("R4 idle blocks /8", nc, 0);
    chk("R5 idle leaves per_ce running", np, 20);
    wr_pwr(1'b0, 1'b0);
    count_win(3, nc, np, first);
    chk("R7 resume from zero pulses at once", first, 0);
    wr_pwr(1'b1, 1'b0);
    count_win(10, nc, np, first);
    chk("R7 no pulse while held", nc, 0);
    wr_pwr(1'b0, 1'b0);
    count_win(8, nc, np, first);
    chk("R7 resume from held count offset", first, 4);
    chk("R7 resume pulse count", nc, 1);

    // R6 debug enable writes
    wr_sel(3'd0, 1'b0);
    chk("R6 dbg cleared", int'(dbg_cmp_en), 0);
    wr_sel(3'd0, 1'b1);
    chk("R6 dbg set", int'(dbg_cmp_en), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule